// File: doc/BRIEF.md
# Ramped Digital Volume Controller

This block multiplies a stream of signed audio samples by a digital gain that glides, rather than jumps, toward a programmed level. A host writes three settings: a target level in half-decibel steps, a slope code in tenths of a decibel per millisecond, and a mute flag. Each accepted sample counts as one tick of the 48 kHz processing rate. The block uses that tick to time its slope and moves its current level one half-decibel step at a time until it meets the effective target.

Mute makes the effective target the bottom level, so the gain fades out at the programmed slope and then gives zero samples. Those are the samples that keep a downstream modulator at half duty. Clearing mute fades the gain back to the stored level. Level writes made while muted are kept for that return. The conversion from level to linear gain uses a twelve-entry mantissa table for one octave plus an arithmetic right shift. The product is saturated to the sample width.

Top module: `vol_ramp_top`

## Requirements
- R1: After reset, the current level, the stored target and the mute flag are all zero, and the slope code is 1. Both `out_valid` and `ramp_active` are low.
- R2: Level index i (9 bits) stands for -100 + 0.5·i dB. A written index above 256 is stored as 256. Index 0 is the mute level, and any sample processed at index 0 gives an output of exactly 0.
- R3: For index i > 0, with k = (i+4) mod 12, o = (i+4) div 12 and M[k] = round(32768·2^(k/12)), the output is floor(x·M[k] / 2^(32−o)) before saturation.
- R4: A result outside the 24-bit signed range is clamped to +8388607 or −8388608.
- R5: `out_valid` rises in the cycle after `in_valid` and never appears otherwise. The output uses the level that was in effect before that clock edge.
- R6: The 6-bit slope code N means N·0.1 dB/ms, and code 0 acts as 1. Each `in_valid` cycle is one tick, 48 ticks make one millisecond, and the level never changes in a cycle without a tick.
- R7: While ramping, an accumulator gains N every 48th tick. On a tick that sees the accumulator at 5 or more, the level moves one step toward the target and 5 is subtracted. The level moves at most one step per cycle and never passes the target.
- R8: When the level equals the effective target, the tick counter and the accumulator are cleared. A new ramp therefore always starts from zero credit.
- R9: With mute set, the effective target is 0 and the level ramps down at the slope. After mute clears, the level ramps back to the stored target, including any value written during mute.
- R10: `ramp_active` is high exactly when the current level differs from the effective target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vol_we | input | 1 | Store `vol_idx` as the target level |
| vol_idx | input | 9 | Target level index, in 0.5 dB steps |
| rate_we | input | 1 | Store `rate_code` |
| rate_code | input | 6 | Slope in 0.1 dB/ms units |
| mute_we | input | 1 | Store `mute_in` |
| mute_in | input | 1 | Mute request |
| in_valid | input | 1 | Sample strobe; also the 48 kHz tick |
| in_sample | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 24 | Signed scaled sample |
| ramp_active | output | 1 | Level differs from the effective target |

## Verification
Each test runs the gain path with full-scale positive and negative samples, small values and random values. Full-scale samples at +28 dB separate correct saturation from wraparound. Random values at levels in every octave show whether the mantissa and shift pair is chosen correctly and whether negative results round toward minus infinity. The slope logic is timed with directed single-step ramps: code 1, code 0 and code 5 starting from a settled state. These show whether code 0 is remapped and whether stale credit carries over into a new ramp. Random sequences of target changes, mute toggles and gaps in the tick stream are compared cycle by cycle with a reference model. They show whether a step lands on the right tick, whether the level overshoots, and whether the level returns after unmute.

// File: rtl/vol_ramp_pkg.sv
package vol_ramp_pkg;

  localparam int MANT_W        = 17;  // Q1.15 mantissa, one spare bit
  localparam int STEPS_PER_OCT = 12;  // 0.5 dB steps per ~6 dB
  localparam int IDX_BIAS      = 4;   // aligns index 200 (0 dB) to an octave edge
  localparam int SHIFT_BASE    = 32;  // 15 mantissa bits + 17 octaves below unity

  // 2^(k/12) in Q15, rounded
  function automatic logic [MANT_W-1:0] mant_lut(input int unsigned k);
    case (k)
      0:       return 17'd32768;
      1:       return 17'd34716;
      2:       return 17'd36781;
      3:       return 17'd38968;
      4:       return 17'd41285;
      5:       return 17'd43740;
      6:       return 17'd46341;
      7:       return 17'd49097;
      8:       return 17'd52016;
      9:       return 17'd55109;
      10:      return 17'd58386;
      11:      return 17'd61858;
      default: return 17'd32768;
    endcase
  endfunction

  function automatic int unsigned oct_of(input int unsigned idx);
    return (idx + IDX_BIAS) / STEPS_PER_OCT;
  endfunction

  function automatic int unsigned frac_of(input int unsigned idx);
    return (idx + IDX_BIAS) % STEPS_PER_OCT;
  endfunction

endpackage

// File: rtl/vol_ramp_ctrl.sv
module vol_ramp_ctrl #(
  parameter int IDX_W        = 9,
  parameter int MAX_IDX      = 256,
  parameter int RATE_W       = 6,
  parameter int TICKS_PER_MS = 48,
  parameter int HALF_DB      = 5     // one level step in 0.1 dB units
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             vol_we,
  input  logic [IDX_W-1:0] vol_idx,
  input  logic             rate_we,
  input  logic [RATE_W-1:0] rate_code,
  input  logic             mute_we,
  input  logic             mute_in,
  output logic [IDX_W-1:0] cur_idx,
  output logic             ramp_active
);

  localparam int ACC_W = RATE_W + 2;
  localparam int MS_W  = $clog2(TICKS_PER_MS);

  logic [IDX_W-1:0]  tgt_q, cur_q, eff_tgt;
  logic [RATE_W-1:0] rate_q;
  logic [ACC_W-1:0]  acc_q;
  logic [MS_W-1:0]   ms_q;
  logic              mute_q;

  // named events
  logic ms_wrap, can_step, step_up, step_dn;

  always_comb begin
    eff_tgt     = mute_q ? '0 : tgt_q;
    ramp_active = (cur_q != eff_tgt);
    ms_wrap     = tick && ramp_active && (ms_q == MS_W'(TICKS_PER_MS - 1));
    can_step    = tick && ramp_active && (acc_q >= ACC_W'(HALF_DB));
    step_up     = can_step && (cur_q < eff_tgt);
    step_dn     = can_step && (cur_q > eff_tgt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      cur_q  <= '0;
      rate_q <= RATE_W'(1);
      mute_q <= 1'b0;
      acc_q  <= '0;
      ms_q   <= '0;
    end else begin
      if (vol_we)
        tgt_q <= (vol_idx > IDX_W'(MAX_IDX)) ? IDX_W'(MAX_IDX) : vol_idx;
      if (rate_we)
        rate_q <= (rate_code == '0) ? RATE_W'(1) : rate_code;
      if (mute_we)
        mute_q <= mute_in;

      if (!ramp_active) begin
        acc_q <= '0;
        ms_q  <= '0;
      end else if (tick) begin
        ms_q  <= ms_wrap ? '0 : ms_q + 1'b1;
        acc_q <= acc_q - (can_step ? ACC_W'(HALF_DB) : '0)
                       + (ms_wrap  ? ACC_W'(rate_q)  : '0);
      end

      if (step_up)      cur_q <= cur_q + 1'b1;
      else if (step_dn) cur_q <= cur_q - 1'b1;
    end
  end

  assign cur_idx = cur_q;

  p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == $past(cur_q)) || (cur_q == $past(cur_q) + 1'b1) || (cur_q + 1'b1 == $past(cur_q)));

  p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cur_q));

  p_no_over_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q < eff_tgt) |=> (cur_q <= $past(eff_tgt)));

  p_no_over_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q > eff_tgt) |=> (cur_q >= $past(eff_tgt)));

  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_active |=> (acc_q == '0) && (ms_q == '0));

  p_rate_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q != '0);

  p_mute_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_q && cur_q == '0) |=> (cur_q == '0) || !mute_q);

endmodule

// File: rtl/vol_gain_mult.sv
module vol_gain_mult
  import vol_ramp_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int IDX_W  = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic [IDX_W-1:0]         gain_idx,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample
);

  localparam int PROD_W = DATA_W + MANT_W + 1;
  localparam logic signed [PROD_W-1:0] PMAX =
    {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] PMIN = -PMAX - 1;

  function automatic logic signed [DATA_W-1:0] clip(input logic signed [PROD_W-1:0] v);
    if (v > PMAX)      return {1'b0, {(DATA_W-1){1'b1}}};
    else if (v < PMIN) return {1'b1, {(DATA_W-1){1'b0}}};
    else               return v[DATA_W-1:0];
  endfunction

  logic [MANT_W-1:0]        mant;
  logic [5:0]               shamt;
  logic signed [PROD_W-1:0] smp_ext, mant_ext, prod, shifted;
  logic signed [DATA_W-1:0] scaled;

  always_comb begin
    mant     = mant_lut(frac_of(32'(gain_idx)));
    shamt    = 6'(SHIFT_BASE - oct_of(32'(gain_idx)));
    smp_ext  = PROD_W'(in_sample);
    mant_ext = $signed({{(PROD_W-MANT_W){1'b0}}, mant});
    prod     = smp_ext * mant_ext;
    shifted  = prod >>> shamt;
    scaled   = (gain_idx == '0) ? '0 : clip(shifted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sample <= scaled;
    end
  end

  p_mute_level_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gain_idx == '0) |=> (out_sample == '0));

  p_valid_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

endmodule

// File: rtl/vol_ramp_top.sv
module vol_ramp_top #(
  parameter int DATA_W       = 24,
  parameter int IDX_W        = 9,
  parameter int MAX_IDX      = 256,
  parameter int RATE_W       = 6,
  parameter int TICKS_PER_MS = 48
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vol_we,
  input  logic [IDX_W-1:0]         vol_idx,
  input  logic                     rate_we,
  input  logic [RATE_W-1:0]        rate_code,
  input  logic                     mute_we,
  input  logic                     mute_in,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample,
  output logic                     ramp_active
);

  logic [IDX_W-1:0] cur_idx;

  vol_ramp_ctrl #(
    .IDX_W(IDX_W), .MAX_IDX(MAX_IDX), .RATE_W(RATE_W),
    .TICKS_PER_MS(TICKS_PER_MS), .HALF_DB(5)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(in_valid),
    .vol_we(vol_we), .vol_idx(vol_idx),
    .rate_we(rate_we), .rate_code(rate_code),
    .mute_we(mute_we), .mute_in(mute_in),
    .cur_idx(cur_idx), .ramp_active(ramp_active)
  );

  vol_gain_mult #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .gain_idx(cur_idx), .out_valid(out_valid), .out_sample(out_sample)
  );

  // R10: activity flag falls only after the level actually moved or the target moved
  p_active_settle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_active && !vol_we && !mute_we && !in_valid) |=> ramp_active);

endmodule

// File: tb/vol_ramp_top_tb.sv
`timescale 1ns/1ps
module vol_ramp_top_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vol_we = 0, rate_we = 0, mute_we = 0, mute_in = 0, in_valid = 0;
  logic [8:0] vol_idx = '0;
  logic [5:0] rate_code = '0;
  logic signed [23:0] in_sample = '0;
  logic out_valid, ramp_active;
  logic signed [23:0] out_sample;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int r_cur = 0, r_tgt = 0, r_rate = 1, r_acc = 0, r_ms = 0;
  bit r_mute = 0;

  longint qtab [12] = '{32768, 34716, 36781, 38968, 41285, 43740,
                        46341, 49097, 52016, 55109, 58386, 61858};

  always #4 clk = ~clk;

  vol_ramp_top u_dut (
    .clk(clk), .rst_n(rst_n), .vol_we(vol_we), .vol_idx(vol_idx),
    .rate_we(rate_we), .rate_code(rate_code), .mute_we(mute_we), .mute_in(mute_in),
    .in_valid(in_valid), .in_sample(in_sample), .out_valid(out_valid),
    .out_sample(out_sample), .ramp_active(ramp_active)
  );

  function automatic longint ref_gain(longint x, int lvl);
    longint num, den, q;
    int shift;
    if (lvl == 0) return 0;
    num   = x * qtab[(lvl + 4) % 12];
    shift = 32 - (lvl + 4) / 12;
    den   = longint'(1) << shift;
    q     = num / den;
    if (num < 0 && q * den != num) q = q - 1;   // floor
    if (q > 8388607)  q = 8388607;
    if (q < -8388608) q = -8388608;
    return q;
  endfunction

  function automatic int eff_target();
    return r_mute ? 0 : r_tgt;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // advance the reference by one clock edge, using the inputs in force
  task automatic ref_edge(bit v);
    int tg;
    bit moving, wrap, credit;
    tg = eff_target();
    moving = (r_cur != tg);
    if (!moving) begin
      r_acc = 0; r_ms = 0;
    end else if (v) begin
      wrap   = (r_ms == 47);
      credit = (r_acc >= 5);
      r_ms   = wrap ? 0 : r_ms + 1;
      r_acc  = r_acc - (credit ? 5 : 0) + (wrap ? r_rate : 0);
      if (credit) r_cur = (r_cur < tg) ? r_cur + 1 : r_cur - 1;
    end
    if (vol_we)  r_tgt  = (vol_idx > 256) ? 256 : int'(vol_idx);
    if (rate_we) r_rate = (rate_code == 0) ? 1 : int'(rate_code);
    if (mute_we) r_mute = mute_in;
  endtask

  // one clock: inputs already at negedge, check at following negedge
  task automatic cycle(bit v, int x);
    longint expv;
    in_valid  = v;
    in_sample = 24'(x);
    expv = ref_gain(longint'(signed'(in_sample)), r_cur);
    @(posedge clk);
    ref_edge(v);
    @(negedge clk);
    vol_we = 0; rate_we = 0; mute_we = 0; in_valid = 0;
    check(out_valid == v, "R5 valid", out_valid, v);
    if (v) check(longint'(out_sample) == expv, "R3 sample", out_sample, expv);
    check(ramp_active == (r_cur != eff_target()), "R10 active", ramp_active,
          (r_cur != eff_target()));
  endtask

  task automatic set_vol(int i);  vol_we = 1; vol_idx = 9'(i);    cycle(0, 0); endtask
  task automatic set_rate(int c); rate_we = 1; rate_code = 6'(c); cycle(0, 0); endtask
  task automatic set_mute(bit m); mute_we = 1; mute_in = m;       cycle(0, 0); endtask

  task automatic ticks_to_idle(int limit, output int n);
    n = 0;
    while (ramp_active && n < limit) begin
      cycle(1, int'($urandom_range(0, 200000)) - 100000);
      n++;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    check(ramp_active == 0, "R1 ramp_active", ramp_active, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: mute level gives zero
    cycle(1, 8388607);
    check(out_sample == 0, "R2 level0 zero", out_sample, 0);

    // R6: default slope 1 -> first step after 241 ticks
    set_vol(1);
    ticks_to_idle(1000, n);
    check(n == 241, "R6 default slope", n, 241);

    // R6: code 0 behaves as 1
    set_rate(0);
    set_vol(2);
    ticks_to_idle(1000, n);
    check(n == 241, "R6 code0 as 1", n, 241);

    // R8: fresh credit after settle, slope 5 -> 49 ticks
    set_rate(5);
    repeat (30) cycle(1, 777);
    set_vol(3);
    ticks_to_idle(1000, n);
    check(n == 49, "R8 fresh ramp", n, 49);

    // R7: fast ramp to top, no overshoot
    set_rate(63);
    set_vol(256);
    ticks_to_idle(5000, n);
    check(r_cur == 256 && ramp_active == 0, "R7 reach top", r_cur, 256);

    // R4: saturation at +28 dB
    cycle(1, 8388607);
    check(out_sample == 24'sd8388607, "R4 pos sat", out_sample, 8388607);
    cycle(1, -8388608);
    check(out_sample == -24'sd8388608, "R4 neg sat", out_sample, -8388608);

    // R2: clamp of indices above 256
    set_vol(400);
    check(ramp_active == 0, "R2 clamp", ramp_active, 0);

    // R9: mute ramps down, stored write during mute, unmute returns
    set_mute(1);
    check(ramp_active == 1, "R9 mute starts ramp", ramp_active, 1);
    ticks_to_idle(5000, n);
    cycle(1, 4000000);
    check(out_sample == 0, "R9 muted output", out_sample, 0);
    set_vol(100);
    check(ramp_active == 0, "R9 write while muted", ramp_active, 0);
    cycle(1, 123456);
    check(out_sample == 0, "R9 still zero", out_sample, 0);
    set_mute(0);
    ticks_to_idle(5000, n);
    cycle(1, 3000000);
    check(longint'(out_sample) == ref_gain(3000000, 100), "R9 unmute level",
          out_sample, ref_gain(3000000, 100));

    // R3: level sweep with fixed samples
    for (int k = 1; k <= 24; k++) begin
      set_rate(63);
      set_vol(k * 10);
      ticks_to_idle(5000, n);
      cycle(1, -1234567);
      check(longint'(out_sample) == ref_gain(-1234567, k * 10), "R3 sweep",
            out_sample, ref_gain(-1234567, k * 10));
    end

    // random episodes
    for (int e = 0; e < 40; e++) begin
      int len;
      case ($urandom_range(0, 3))
        0: set_rate(int'($urandom_range(0, 63)));
        1: set_vol(int'($urandom_range(0, 300)));
        2: set_mute(1'($urandom_range(0, 1)));
        default: begin set_vol(int'($urandom_range(0, 256))); set_rate(int'($urandom_range(20, 63))); end
      endcase
      len = int'($urandom_range(100, 1500));
      for (int c = 0; c < len; c++)
        cycle($urandom_range(0, 7) != 0, int'($urandom_range(0, 16777215)) - 8388608);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule